// File: doc/BRIEF.md
# Reconfigurable Arithmetic Processing Tile

This block is one cell of a mesh of arithmetic tiles. Each tile holds a small routing switch and a single arithmetic unit. Four 16-bit links arrive from the neighbouring tiles on the north, east, south and west sides. A configuration word picks which link feeds operand A and which feeds operand B. It gives each operand its own delay of zero to three clocks, so that values which reach the tile at different times meet again at the unit. It also lists the neighbour links that receive the registered result.

The unit is chosen when the tile is built, by a parameter. The adder variant adds the two operands, and either operand can be negated first. The multiplier variant forms the signed 32-bit product and returns a 16-bit window of it, chosen by an arithmetic right shift. Its B operand can come from a constant held in the configuration word instead of from a link.

An outside loader presents a complete configuration word and pulses a load strobe. The whole tile switches to the new setting at that one clock edge. Data keeps flowing on every clock, before and after the switch.

Top module: `rcfg_tile`

## Requirements
- R1: A synchronous active-high reset clears the configuration to all zeros and forces all four output links to zero in the cycle after the reset edge.
- R2: The A-select field (bits 1:0) and the B-select field (bits 3:2) use the encoding 0=north, 1=east, 2=south, 3=west. Each field picks the input link that feeds its operand.
- R3: In the adder variant, bit 4 negates A and bit 5 negates B, both in two's complement, before the addition. The result is the sum modulo 2^16, so A+B, A-B, -A+B and -A-B can all be formed.
- R4: Bits 7:6 delay operand A and bits 9:8 delay operand B, each by 0 to 3 clocks. The two delays are independent.
- R5: In the multiplier variant, the result is the low 16 bits of (signed A × signed B) shifted arithmetically right by the amount in bits 15:11. Amounts above 16 act as 16.
- R6: In the multiplier variant, when bit 10 is set, operand B is the constant in bits 31:16 and the B link has no effect on the result.
- R7: Bits 35:32 enable the north, east, south and west output links, in that order. Every enabled link carries the same result, and every disabled link drives zero.
- R8: A result appears on the output links one clock after the edge at which its operands, after their delays, are sampled. With both delays at zero, inputs sampled at edge k show at the outputs right after edge k.
- R9: The configuration word is taken at an edge where the load strobe is high, and it governs operands from the next edge onward. When the strobe is low, changes on the word have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load strobe for the configuration word |
| cfg_word | input | 36 | Parallel configuration word (field layout in R2 to R7) |
| lnk_n_i | input | 16 | Link from the north neighbour |
| lnk_e_i | input | 16 | Link from the east neighbour |
| lnk_s_i | input | 16 | Link from the south neighbour |
| lnk_w_i | input | 16 | Link from the west neighbour |
| lnk_n_o | output | 16 | Result link to the north neighbour |
| lnk_e_o | output | 16 | Result link to the east neighbour |
| lnk_s_o | output | 16 | Result link to the south neighbour |
| lnk_w_o | output | 16 | Result link to the west neighbour |

## Verification
A wrong delay-stage value appears on the enabled output links exactly as many clocks after the offending input as the configured delay. A wrong select or negate setting corrupts the very next result. A configuration register that loads when it should not, or that keeps a stale value, shows as results that follow the wrong setting from the first edge after the load strobe. Because the outputs are compared with a behavioural model on every clock, any of these faults is seen within at most four cycles of its cause.

// File: rtl/rcfg_tile_pkg.sv
package rcfg_tile_pkg;
  localparam int DW     = 16;
  localparam int NLINK  = 4;
  localparam int SEL_W  = $clog2(NLINK);
  localparam int DLY_W  = 2;
  localparam int SH_W   = 5;

  typedef enum logic [SEL_W-1:0] {
    LNK_N = 2'd0,
    LNK_E = 2'd1,
    LNK_S = 2'd2,
    LNK_W = 2'd3
  } link_e;

  // Declared MSB first: out_en occupies the top bits, sel_a the bottom.
  typedef struct packed {
    logic [NLINK-1:0] out_en;
    logic [DW-1:0]    konst;
    logic [SH_W-1:0]  shamt;
    logic             use_k;
    logic [DLY_W-1:0] dly_b;
    logic [DLY_W-1:0] dly_a;
    logic             neg_b;
    logic             neg_a;
    link_e            sel_b;
    link_e            sel_a;
  } tile_cfg_t;

  localparam int CFG_W = $bits(tile_cfg_t);
endpackage

// File: rtl/rcfg_link_mux.sv
module rcfg_link_mux #(
  parameter int W = 16,
  parameter int N = 4,
  localparam int SW = $clog2(N)
) (
  input  logic [N-1:0][W-1:0] din,
  input  logic [SW-1:0]       sel,
  output logic [W-1:0]        dout
);
  always_comb begin
    dout = '0;
    for (int i = 0; i < N; i++) begin
      if (sel == SW'(i)) dout = din[i];
    end
  end
endmodule

// File: rtl/rcfg_delay_line.sv
module rcfg_delay_line #(
  parameter int W     = 16,
  parameter int DEPTH = 3,
  parameter int DW_SEL = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [W-1:0]      din,
  input  logic [DW_SEL-1:0] dly,
  output logic [W-1:0]      dout
);
  logic [W-1:0] stg [DEPTH];

  // Data stages carry no reset so they can map onto shift-register cells.
  always_ff @(posedge clk) stg[0] <= din;

  for (genvar s = 1; s < DEPTH; s++) begin : g_stage
    always_ff @(posedge clk) stg[s] <= stg[s-1];
  end

  always_comb begin
    dout = din;
    for (int s = 0; s < DEPTH; s++) begin
      if (int'(dly) == s + 1) dout = stg[s];
    end
    if (int'(dly) > DEPTH) dout = stg[DEPTH-1];
  end

  assert_tap_one_R4: assert property (@(posedge clk) disable iff (rst)
    (dly == DW_SEL'(1)) |-> (dout == $past(din)));
endmodule

// File: rtl/rcfg_addsub.sv
module rcfg_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         neg_a,
  input  logic         neg_b,
  output logic [W-1:0] y
);
  logic [W-1:0] a_s, b_s, both_neg;

  always_comb begin
    a_s = neg_a ? (~a + W'(1)) : a;
    b_s = neg_b ? (~b + W'(1)) : b;
    y   = a_s + b_s;
  end

  always_comb begin
    both_neg = W'(0) - (a + b);
    if (neg_a && neg_b) begin
      assert_neg_both_R3: assert (y == both_neg);
    end
  end
endmodule

// File: rtl/rcfg_shift_mul.sv
module rcfg_shift_mul #(
  parameter int W    = 16,
  parameter int SH_W = 5
) (
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic            use_k,
  input  logic [W-1:0]    konst,
  input  logic [SH_W-1:0] shamt,
  output logic [W-1:0]    y
);
  localparam int PW = 2 * W;

  logic [W-1:0]          b_eff;
  logic [SH_W-1:0]       sh_c;
  logic signed [PW-1:0]  prod;
  logic signed [PW-1:0]  scaled;

  always_comb begin
    b_eff  = use_k ? konst : b;
    sh_c   = (int'(shamt) > W) ? SH_W'(W) : shamt;
    prod   = PW'($signed(a)) * PW'($signed(b_eff));
    scaled = prod >>> sh_c;
    y      = scaled[W-1:0];
  end

  always_comb begin
    if (use_k && konst == '0) begin
      assert_const_zero_R6: assert (y == '0);
    end
    if (!use_k && b == W'(1) && shamt == '0) begin
      assert_unit_gain_R5: assert (y == a);
    end
  end
endmodule

// File: rtl/rcfg_tile.sv
module rcfg_tile
  import rcfg_tile_pkg::*;
#(
  parameter bit IS_MULT = 1'b0,
  parameter int MAX_DLY = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_load,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic [DW-1:0]    lnk_n_i,
  input  logic [DW-1:0]    lnk_e_i,
  input  logic [DW-1:0]    lnk_s_i,
  input  logic [DW-1:0]    lnk_w_i,
  output logic [DW-1:0]    lnk_n_o,
  output logic [DW-1:0]    lnk_e_o,
  output logic [DW-1:0]    lnk_s_o,
  output logic [DW-1:0]    lnk_w_o
);
  tile_cfg_t                 cfg_q;
  logic [NLINK-1:0][DW-1:0]  lnk_vec;
  logic [NLINK-1:0][DW-1:0]  out_q;
  logic [DW-1:0]             op_a, op_b, tap_a, tap_b, fu_y;

  assign lnk_vec = {lnk_w_i, lnk_s_i, lnk_e_i, lnk_n_i};

  always_ff @(posedge clk) begin
    if (rst)           cfg_q <= '0;
    else if (cfg_load) cfg_q <= tile_cfg_t'(cfg_word);
  end

  rcfg_link_mux #(.W(DW), .N(NLINK)) u_mux_a (
    .din(lnk_vec), .sel(cfg_q.sel_a), .dout(op_a));
  rcfg_link_mux #(.W(DW), .N(NLINK)) u_mux_b (
    .din(lnk_vec), .sel(cfg_q.sel_b), .dout(op_b));

  rcfg_delay_line #(.W(DW), .DEPTH(MAX_DLY), .DW_SEL(DLY_W)) u_dly_a (
    .clk(clk), .rst(rst), .din(op_a), .dly(cfg_q.dly_a), .dout(tap_a));
  rcfg_delay_line #(.W(DW), .DEPTH(MAX_DLY), .DW_SEL(DLY_W)) u_dly_b (
    .clk(clk), .rst(rst), .din(op_b), .dly(cfg_q.dly_b), .dout(tap_b));

  if (IS_MULT) begin : g_mul
    rcfg_shift_mul #(.W(DW), .SH_W(SH_W)) u_fu (
      .a(tap_a), .b(tap_b), .use_k(cfg_q.use_k), .konst(cfg_q.konst),
      .shamt(cfg_q.shamt), .y(fu_y));
  end else begin : g_add
    rcfg_addsub #(.W(DW)) u_fu (
      .a(tap_a), .b(tap_b), .neg_a(cfg_q.neg_a), .neg_b(cfg_q.neg_b),
      .y(fu_y));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
    end else begin
      for (int i = 0; i < NLINK; i++) begin
        out_q[i] <= cfg_q.out_en[i] ? fu_y : '0;
      end
    end
  end

  assign lnk_n_o = out_q[0];
  assign lnk_e_o = out_q[1];
  assign lnk_s_o = out_q[2];
  assign lnk_w_o = out_q[3];

  // Assertions
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (lnk_n_o == '0 && lnk_e_o == '0 &&
                    lnk_s_o == '0 && lnk_w_o == '0 && cfg_q == '0));

  for (genvar i = 0; i < NLINK; i++) begin : g_chk
    assert_unsel_zero_R7: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(cfg_q.out_en[i])) |-> (out_q[i] == '0));
  end

  assert_fanout_equal_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cfg_q.out_en[0]) && $past(cfg_q.out_en[2]))
      |-> (lnk_n_o == lnk_s_o));

  assert_result_latency_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cfg_q.out_en[1])) |-> (lnk_e_o == $past(fu_y)));

  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cfg_load)) |-> $stable(cfg_q));

  assert_cfg_take_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cfg_load)) |-> (cfg_q == $past(cfg_word)));
endmodule

// File: tb/rcfg_tile_tb_top.sv
module rcfg_tile_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_load = 1'b0;
  logic [35:0] cfg_word = '0;
  logic [15:0] l_in [4];
  logic [15:0] o_add [4];
  logic [15:0] o_mul [4];

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";

  // behavioural model state: [unit][...], unit 0 = adder, 1 = multiplier
  logic [35:0] m_cfg = '0;
  logic [15:0] hA [2][3];
  logic [15:0] hB [2][3];
  logic [15:0] mo [2][4];
  logic [31:0] rs = 32'h1ACE_B00C;

  always #5 clk = ~clk;

  initial begin
    for (int i = 0; i < 4; i++) l_in[i] = '0;
    for (int u = 0; u < 2; u++) begin
      for (int k = 0; k < 3; k++) begin hA[u][k] = '0; hB[u][k] = '0; end
      for (int k = 0; k < 4; k++) mo[u][k] = '0;
    end
  end

  rcfg_tile #(.IS_MULT(1'b0)) dut_i (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_word(cfg_word),
    .lnk_n_i(l_in[0]), .lnk_e_i(l_in[1]), .lnk_s_i(l_in[2]), .lnk_w_i(l_in[3]),
    .lnk_n_o(o_add[0]), .lnk_e_o(o_add[1]), .lnk_s_o(o_add[2]), .lnk_w_o(o_add[3]));

  rcfg_tile #(.IS_MULT(1'b1)) dut_m_i (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_word(cfg_word),
    .lnk_n_i(l_in[0]), .lnk_e_i(l_in[1]), .lnk_s_i(l_in[2]), .lnk_w_i(l_in[3]),
    .lnk_n_o(o_mul[0]), .lnk_e_o(o_mul[1]), .lnk_s_o(o_mul[2]), .lnk_w_o(o_mul[3]));

  function automatic logic [35:0] mk(int sa, int sb, bit na, bit nb, int da, int db,
                                     bit uk, int sh, logic [15:0] k, logic [3:0] en);
    logic [35:0] c;
    c = '0;
    c[1:0] = 2'(sa); c[3:2] = 2'(sb); c[4] = na; c[5] = nb;
    c[7:6] = 2'(da); c[9:8] = 2'(db); c[10] = uk; c[15:11] = 5'(sh);
    c[31:16] = k; c[35:32] = en;
    return c;
  endfunction

  function automatic logic [15:0] fu(int u, logic [35:0] c, logic [15:0] a, logic [15:0] b);
    int ai, bi, p, sh;
    logic [15:0] x, y;
    if (u == 1) begin
      if (c[10]) b = c[31:16];
      ai = int'($signed(a));
      bi = int'($signed(b));
      p  = ai * bi;
      sh = int'(c[15:11]);
      if (sh > 16) sh = 16;
      p = p >>> sh;
      return p[15:0];
    end
    x = c[4] ? 16'(0 - int'(a)) : a;
    y = c[5] ? 16'(0 - int'(b)) : b;
    return 16'(int'(x) + int'(y));
  endfunction

  task automatic model_edge();
    logic [15:0] sa, sb, ta, tb, r;
    int da, db;
    for (int u = 0; u < 2; u++) begin
      sa = l_in[m_cfg[1:0]];
      sb = l_in[m_cfg[3:2]];
      da = int'(m_cfg[7:6]);
      db = int'(m_cfg[9:8]);
      ta = (da == 0) ? sa : hA[u][da-1];
      tb = (db == 0) ? sb : hB[u][db-1];
      r  = fu(u, m_cfg, ta, tb);
      for (int i = 0; i < 4; i++) mo[u][i] = (!rst && m_cfg[32+i]) ? r : 16'h0;
      hA[u][2] = hA[u][1]; hA[u][1] = hA[u][0]; hA[u][0] = sa;
      hB[u][2] = hB[u][1]; hB[u][1] = hB[u][0]; hB[u][0] = sb;
    end
    if (rst) m_cfg = '0;
    else if (cfg_load) m_cfg = cfg_word;
  endtask

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    for (int i = 0; i < 4; i++) begin
      chk(cur_req, $sformatf("adder link %0d", i), o_add[i], mo[0][i]);
      chk(cur_req, $sformatf("mult link %0d", i), o_mul[i], mo[1][i]);
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic load(logic [35:0] c);
    cfg_word = c;
    cfg_load = 1'b1;
    step();
    cfg_load = 1'b0;
  endtask

  task automatic rnd_links();
    for (int i = 0; i < 4; i++) begin
      rs = {rs[30:0], rs[31] ^ rs[21] ^ rs[1] ^ rs[0]};
      rs = {rs[30:0], rs[31] ^ rs[21] ^ rs[1] ^ rs[0]};
      l_in[i] = rs[15:0] ^ rs[31:16];
    end
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++) begin
      rnd_links();
      step();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5) step();
    @(negedge clk);
    rst = 1'b0;
    cur_req = "R1";
    step();
    for (int i = 0; i < 4; i++) begin
      chk("R1", "adder out after reset", o_add[i], 16'h0);
      chk("R1", "mult out after reset", o_mul[i], 16'h0);
    end
    run(3);

    // R8: zero delay, result one clock after sampling
    cur_req = "R8";
    load(mk(0, 2, 0, 0, 0, 0, 0, 0, 16'h0, 4'b0001));
    l_in[0] = 16'd100; l_in[2] = 16'd23;
    step();
    chk("R8", "adder north next edge", o_add[0], 16'd123);
    chk("R8", "mult north next edge", o_mul[0], 16'd2300);

    // R2: every select code on A and B
    cur_req = "R2";
    for (int s = 0; s < 4; s++) begin
      load(mk(s, 3 - s, 0, 0, 0, 0, 0, 0, 16'h0, 4'b0010));
      run(6);
    end
    l_in[0] = 16'd1; l_in[1] = 16'd20; l_in[2] = 16'd300; l_in[3] = 16'd4000;
    load(mk(1, 3, 0, 0, 0, 0, 0, 0, 16'h0, 4'b0010));
    l_in[0] = 16'd1; l_in[1] = 16'd20; l_in[2] = 16'd300; l_in[3] = 16'd4000;
    step();
    chk("R2", "east+west sum", o_add[1], 16'd4020);

    // R3: all negate combinations, including extreme values
    cur_req = "R3";
    for (int n = 0; n < 4; n++) begin
      load(mk(0, 1, n[0], n[1], 0, 0, 0, 0, 16'h0, 4'b1111));
      run(8);
      l_in[0] = 16'h8000; l_in[1] = 16'h7FFF;
      step();
    end
    load(mk(0, 1, 1, 0, 0, 0, 0, 0, 16'h0, 4'b0001));
    l_in[0] = 16'd5; l_in[1] = 16'd3;
    step();
    chk("R3", "-A+B", o_add[0], 16'hFFFE);

    // R4: independent operand delays with a pulse
    cur_req = "R4";
    l_in[0] = '0; l_in[2] = '0;
    load(mk(0, 2, 0, 0, 2, 0, 0, 0, 16'h0, 4'b0001));
    step();
    l_in[0] = 16'd55;
    step();
    l_in[0] = 16'd0;
    step();
    chk("R4", "delay 2 not yet", o_add[0], 16'd0);
    step();
    chk("R4", "delay 2 arrival", o_add[0], 16'd55);
    for (int d = 0; d < 16; d++) begin
      load(mk(3, 1, 0, 1, d % 4, d / 4, 0, 0, 16'h0, 4'b0101));
      run(6);
    end

    // R5: multiplier window
    cur_req = "R5";
    load(mk(0, 1, 0, 0, 0, 0, 0, 16, 16'h0, 4'b0001));
    l_in[0] = 16'h4000; l_in[1] = 16'h4000;
    step();
    chk("R5", "shift16 window", o_mul[0], 16'h1000);
    load(mk(0, 1, 0, 0, 0, 0, 0, 20, 16'h0, 4'b0001));
    l_in[0] = 16'hFFFF; l_in[1] = 16'h0001;
    step();
    chk("R5", "shift above 16 acts as 16", o_mul[0], 16'hFFFF);
    for (int s = 0; s < 32; s += 3) begin
      load(mk(2, 3, 0, 0, 1, 0, 0, s, 16'h0, 4'b1000));
      run(5);
    end

    // R6: constant B, link ignored
    cur_req = "R6";
    load(mk(0, 1, 0, 0, 0, 0, 1, 0, 16'd3, 4'b0001));
    l_in[0] = 16'd7; l_in[1] = 16'd999;
    step();
    chk("R6", "A*const", o_mul[0], 16'd21);
    l_in[1] = 16'd12345;
    step();
    chk("R6", "B link ignored", o_mul[0], 16'd21);
    load(mk(2, 0, 0, 0, 0, 0, 1, 4, 16'hFF80, 4'b0110));
    run(10);

    // R7: fan-out to north and south
    cur_req = "R7";
    load(mk(0, 1, 0, 0, 0, 0, 0, 0, 16'h0, 4'b0101));
    l_in[0] = 16'd9; l_in[1] = 16'd8;
    step();
    chk("R7", "north result", o_add[0], 16'd17);
    chk("R7", "south result", o_add[2], 16'd17);
    chk("R7", "east disabled", o_add[1], 16'd0);
    chk("R7", "west disabled", o_add[3], 16'd0);
    run(6);

    // R9: word changes without the strobe have no effect
    cur_req = "R9";
    cfg_word = mk(3, 3, 1, 1, 0, 0, 0, 0, 16'h0, 4'b1111);
    l_in[0] = 16'd2; l_in[1] = 16'd4;
    step();
    chk("R9", "old config kept north", o_add[0], 16'd6);
    chk("R9", "old config kept west", o_add[3], 16'd0);
    run(5);
    load(mk(3, 2, 0, 1, 1, 2, 1, 2, 16'd7, 4'b1001));
    run(12);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule